// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block produces the serial clock for an I2C master from a reloadable down-counter. A phase-tick strobe arrives twice per instruction cycle. The counter loses one count on each tick. A transmit-buffer write, seen here as a one-cycle start strobe, latches the lower seven bits of the divisor register as the reload value N and starts the count. Each time the counter runs out, the block emits a rollover pulse. Two rollovers make one SCL period, so the SCL frequency is Fcy / (N+1). For example, with a 10 MHz instruction rate, N = 0x18 gives 400 kHz and N = 0x63 gives 100 kHz.

In master mode the counter reloads itself after every rollover, and the registered SCL output toggles on each one. After nine SCL cycles (eight data bits and the acknowledge), the block stops, pulses done and holds SCL at its final level. With master mode off, a start gives one count-down and then the counter rests at zero. A start with a zero reload value is refused and flagged.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, scl is 1 and busy, rollover, done and div_err are all 0.
- R2: A start strobe while not busy, with divisor bits [6:0] not zero, sets busy on the next cycle. Divisor bit 7 has no effect on the timing.
- R3: A rollover pulse lasts one cycle and comes after every N+1 phase ticks counted from the start. Clock cycles without a tick do not advance the count.
- R4: In master mode, scl goes to 0 on the first rollover after the start and inverts on every later rollover. It changes at no other time.
- R5: In master mode the transfer ends after 18 rollovers (9 SCL cycles). In the cycle of the 18th rollover, done pulses for one cycle and busy drops. After that, scl stays at 1 and no further rollover occurs until the next start.
- R6: A start strobe while not busy with divisor bits [6:0] equal to 0 gives a one-cycle div_err pulse on the next cycle and leaves busy at 0.
- R7: With master_mode at 0 when the start is accepted, the counter counts down once. It gives exactly one rollover after N+1 ticks and then stops, with busy at 0, scl unchanged at 1 and no done pulse.
- R8: A start strobe while busy is ignored. The transfer keeps its rollover spacing and its count of 18 rollovers.
- R9: The reload value is captured at the accepted start. Changing the divisor during a transfer does not change the rollover spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Phase-tick strobe, asserted twice per instruction cycle |
| divisor | input | 8 | Divisor register; bits [6:0] are the reload value N |
| start | input | 1 | Transmit-buffer write strobe, starts a count |
| master_mode | input | 1 | 1: auto-reload and SCL toggling; 0: single count-down |
| scl | output | 1 | Registered serial clock, 1 when idle |
| rollover | output | 1 | One-cycle pulse when the counter runs out |
| busy | output | 1 | Counting in progress |
| done | output | 1 | One-cycle pulse when the 9th SCL cycle completes |
| div_err | output | 1 | One-cycle pulse when a start is refused for N = 0 |

## Verification
Transfers run with tick asserted every cycle, every second cycle and every third cycle. This separates counting per tick from counting per clock cycle. The reload values tested are the smallest (1), the largest (0x7F), a typical value, and a value with bit 7 set whose lower bits match another test, which shows that the upper bit has no effect. In one transfer a second start and a new divisor arrive part-way through, to show that the reload value is latched and that restarts are ignored. A single count-down with master mode off and a start with zero lower bits cover the one-shot and refusal paths.

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int REG_W      = 8,
  parameter int DIV_W      = 7,
  parameter int SCL_CYCLES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [REG_W-1:0] divisor,
  input  logic             start,
  input  logic             master_mode,
  output logic             scl,
  output logic             rollover,
  output logic             busy,
  output logic             done,
  output logic             div_err
);
  localparam int EDGES = 2 * SCL_CYCLES;
  localparam int EW    = $clog2(EDGES + 1);

  logic [DIV_W-1:0] cnt, rld;
  logic [EW-1:0]    edges;
  logic             oneshot;

  wire [DIV_W-1:0] n_in   = divisor[DIV_W-1:0];
  wire             zero_n = (n_in == '0);
  wire             launch = start && !busy && !zero_n;
  wire             hit    = busy && tick && (cnt == '0);
  wire             final_edge = edges == EW'(EDGES - 1);
  wire             stop   = oneshot || final_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      rld      <= '0;
      edges    <= '0;
      oneshot  <= 1'b0;
      busy     <= 1'b0;
      scl      <= 1'b1;
      rollover <= 1'b0;
      done     <= 1'b0;
      div_err  <= 1'b0;
    end else begin
      rollover <= hit;
      done     <= hit && !oneshot && final_edge;
      div_err  <= start && !busy && zero_n;
      if (launch) begin
        cnt     <= n_in;
        rld     <= n_in;
        edges   <= '0;
        oneshot <= !master_mode;
        busy    <= 1'b1;
      end else if (hit) begin
        if (!oneshot) scl <= ~scl;
        edges <= edges + 1'b1;
        if (stop) busy <= 1'b0;
        else      cnt  <= rld;
      end else if (busy && tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assert_err_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && zero_n) |=> (div_err && !busy));

  assert_scl_only_on_rollover_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl != $past(scl)) |-> rollover);

  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= rld));

  assert_rollover_from_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |-> $past(busy));

  assert_done_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && scl && rollover));

  assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(rld));
endmodule

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] divisor = 8'h00;
  logic start = 1'b0;
  logic master_mode = 1'b1;
  logic scl, rollover, busy, done, div_err;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  scl_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .divisor(divisor), .start(start),
    .master_mode(master_mode), .scl(scl), .rollover(rollover), .busy(busy),
    .done(done), .div_err(div_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    chk(scl == 1'b1, "R1 scl", scl, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(rollover == 1'b0, "R1 rollover", rollover, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(div_err == 1'b0, "R1 div_err", div_err, 0);
  endtask

  task automatic run_xfer(input logic [7:0] div, input int period, input bit mode, input bit disturb);
    int n = int'(div[6:0]);
    int ticks = 0, nroll = 0, ndone = 0, bad_gap = 0, bad_scl = 0;
    int exp_roll = mode ? 18 : 1;
    @(negedge clk);
    divisor = div; master_mode = mode; start = 1'b1; tick = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    for (int cyc = 0; cyc < 20000; cyc++) begin
      tick = (cyc % period) == 0;
      if (tick) ticks++;
      if (disturb && cyc == 7) begin start = 1'b1; divisor = div ^ 8'h15; master_mode = ~mode; end
      if (disturb && cyc == 8) start = 1'b0;
      @(negedge clk);
      if (rollover) begin
        nroll++;
        if (ticks != n + 1) begin bad_gap++; chk(0, "R3 rollover gap", ticks, n + 1); end
        if (mode && scl != nroll[0] ^ 1'b1) begin
          bad_scl++; chk(0, "R4 scl level", scl, nroll[0] ^ 1'b1);
        end
        if (!mode && scl != 1'b1) begin bad_scl++; chk(0, "R7 scl held", scl, 1); end
        ticks = 0;
      end
      if (done) begin
        ndone++;
        chk(!busy && scl, "R5 done frozen", {busy, scl}, 1);
      end
      if (!busy) break;
    end
    tick = 1'b0;
    chk(bad_gap == 0, disturb ? "R9 R8 spacing kept" : "R3 spacing", bad_gap, 0);
    chk(bad_scl == 0, mode ? "R4 toggles" : "R7 scl", bad_scl, 0);
    chk(nroll == exp_roll, mode ? (disturb ? "R8 rollover count" : "R5 rollover count") : "R7 one rollover",
        nroll, exp_roll);
    chk(ndone == (mode ? 1 : 0), mode ? "R5 one done" : "R7 no done", ndone, mode ? 1 : 0);
    nroll = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      tick = 1'b1;
      @(negedge clk);
      if (rollover || busy || scl != 1'b1) nroll++;
    end
    tick = 1'b0;
    chk(nroll == 0, mode ? "R5 stays stopped" : "R7 stays stopped", nroll, 0);
  endtask

  task automatic test_zero_div();
    @(negedge clk);
    divisor = 8'h80; master_mode = 1'b1; start = 1'b1; tick = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(div_err == 1'b1, "R6 div_err pulse", div_err, 1);
    chk(busy == 1'b0, "R6 not busy", busy, 0);
    @(negedge clk);
    chk(div_err == 1'b0, "R6 div_err single cycle", div_err, 0);
    for (int cyc = 0; cyc < 10; cyc++) begin
      @(negedge clk);
      chk(!rollover && !busy && scl, "R6 no activity", {rollover, busy, scl}, 1);
    end
    tick = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_xfer(8'h03, 1, 1'b1, 1'b0);
    run_xfer(8'h83, 1, 1'b1, 1'b0);
    run_xfer(8'h18, 3, 1'b1, 1'b0);
    run_xfer(8'h05, 2, 1'b1, 1'b1);
    run_xfer(8'h01, 1, 1'b1, 1'b0);
    run_xfer(8'h7F, 1, 1'b1, 1'b0);
    run_xfer(8'h09, 1, 1'b0, 1'b0);
    run_xfer(8'h27, 2, 1'b0, 1'b0);
    test_zero_div();
    run_xfer(8'h02, 1, 1'b1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule